// File: doc/BRIEF.md
# DMA Memory Address and Strobe Generator

This block holds the address state of a multi-channel DMA engine and turns it into the 24-bit memory address and the memory command strobes for each transfer. Every channel keeps a 16-bit current address, a 16-bit remaining count, an 8-bit page and their reload copies. Byte channels put the page above the current address. Word channels shift the current address left by one, so bit 0 of the address is always 0.

A controller outside the block selects the active channel, raises `dma_cyc` while a DMA cycle runs, and pulses `step` once for each transfer. On each step the current address moves by one and the count drops by one. When the count passes zero the terminal-count flag rises. If the channel is in auto-initialize mode, it then reloads from its base values. The memory strobes are decoded from a 27-bit extended address: the general strobes only below 16 MB, the low-memory strobes only below 1 MB. Only the strobe for the active direction is driven.

Top module: `dma_addr_strobe_gen`

## Requirements
- R1: On a byte channel (index below 4), `mem_addr` equals {page[7:0], current[15:0]}.
- R2: On a word channel (index 4 to 7), `mem_addr` equals {page[7:1], current[15:0], 1'b0}.
- R3: A `step` on the active channel adds 1 to its current address when mode bit 0 is 0, and subtracts 1 when mode bit 0 is 1.
- R4: Each `step` lowers the count by 1. `tc` is high during a step in which the count is 0.
- R5: When mode bit 1 is 1, a step with the count at 0 reloads the current address and the count from their base values.
- R6: When mode bit 1 is 0, a step with the count at 0 leaves the count at FFFFh and moves the address on as usual.
- R7: The general strobes `mem_rd_o` and `mem_wr_o` are driven only when `ext_hi` is 0, which means the address is below 16 MB.
- R8: The low strobes `low_rd_o` and `low_wr_o` are driven only when `ext_hi` is 0 and `mem_addr[23:20]` is 0, which means the address is below 1 MB.
- R9: When `mem_read` is 1, only the read strobes can be driven. When it is 0, only the write strobes can be driven.
- R10: `aen_o` and `ale_o` are high exactly while `dma_cyc` is high. Every strobe is low while `dma_cyc` is low.
- R11: A configuration write takes effect at the next clock edge and wins over a `step` in the same cycle. The encodings of `cfg_sel` are 0 for base address, 1 for base count, 2 for page and 3 for mode. A base write also loads the matching current register.
- R12: After reset every register is 0, so channel 0 shows address 0 and the strobes are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 3 | Channel being written |
| cfg_sel | input | 2 | Register select: 0 base address, 1 base count, 2 page, 3 mode |
| cfg_data | input | 16 | Write data; for mode, bit 0 selects decrement and bit 1 selects auto-initialize |
| step | input | 1 | One transfer done on the active channel |
| act_ch | input | 3 | Active channel number |
| mem_read | input | 1 | 1 = memory read cycle, 0 = memory write cycle |
| dma_cyc | input | 1 | A DMA cycle is in progress |
| ext_hi | input | 3 | Address bits 26:24 of the extended address |
| mem_addr | output | 24 | Memory address of the active channel |
| tc | output | 1 | Terminal count for the current step |
| mem_rd_o | output | 1 | General memory read strobe (active high) |
| mem_wr_o | output | 1 | General memory write strobe (active high) |
| low_rd_o | output | 1 | Low-memory read strobe (active high) |
| low_wr_o | output | 1 | Low-memory write strobe (active high) |
| aen_o | output | 1 | Address enable |
| ale_o | output | 1 | Address latch enable |

## Verification
A wrong counter or page value shows up on `mem_addr` as soon as that channel is selected. The address and strobes are combinational from the registers, so the fault is visible in the same cycle. A missed reload, or a wrong wrap at terminal count, shows on the step after the count reaches 0. This is the step that must either bring back the base address or carry on from it. A wrong threshold decode shows at once on the strobes when the address sits on either side of the 1 MB or 16 MB boundary.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;
  typedef enum logic [1:0] {
    SEL_BASE_ADDR = 2'd0,
    SEL_BASE_CNT  = 2'd1,
    SEL_PAGE      = 2'd2,
    SEL_MODE      = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_addr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [1:0]        wr_sel,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              step_hit,
  output logic [CNT_W-1:0]  cur_addr,
  output logic [PAGE_W-1:0] page,
  output logic              tc_now
);
  logic [CNT_W-1:0]  base_addr_q, base_cnt_q, cur_addr_q, cur_cnt_q;
  logic [CNT_W-1:0]  base_addr_d, base_cnt_d, cur_addr_d, cur_cnt_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic              dec_q, dec_d, auto_q, auto_d;
  logic              cnt_zero;

  assign cnt_zero = (cur_cnt_q == '0);

  always_comb begin
    base_addr_d = base_addr_q;
    base_cnt_d  = base_cnt_q;
    cur_addr_d  = cur_addr_q;
    cur_cnt_d   = cur_cnt_q;
    page_d      = page_q;
    dec_d       = dec_q;
    auto_d      = auto_q;
    if (wr_hit) begin
      case (cfg_sel_e'(wr_sel))
        SEL_BASE_ADDR: begin base_addr_d = wr_data; cur_addr_d = wr_data; end
        SEL_BASE_CNT:  begin base_cnt_d  = wr_data; cur_cnt_d  = wr_data; end
        SEL_PAGE:      page_d = wr_data[PAGE_W-1:0];
        default:       begin dec_d = wr_data[0]; auto_d = wr_data[1]; end
      endcase
    end else if (step_hit) begin
      if (cnt_zero && auto_q) begin
        cur_addr_d = base_addr_q;
        cur_cnt_d  = base_cnt_q;
      end else begin
        cur_addr_d = dec_q ? cur_addr_q - 1'b1 : cur_addr_q + 1'b1;
        cur_cnt_d  = cur_cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_addr_q  <= '0;
      cur_cnt_q   <= '0;
      page_q      <= '0;
      dec_q       <= 1'b0;
      auto_q      <= 1'b0;
    end else if (wr_hit || step_hit) begin
      base_addr_q <= base_addr_d;
      base_cnt_q  <= base_cnt_d;
      cur_addr_q  <= cur_addr_d;
      cur_cnt_q   <= cur_cnt_d;
      page_q      <= page_d;
      dec_q       <= dec_d;
      auto_q      <= auto_d;
    end
  end

  assign cur_addr = cur_addr_q;
  assign page     = page_q;
  assign tc_now   = step_hit && cnt_zero;
endmodule

// File: rtl/dma_addr_form.sv
module dma_addr_form #(
  parameter int CNT_W  = 16,
  parameter int PAGE_W = 8,
  localparam int ADDR_W = CNT_W + PAGE_W
) (
  input  logic              word_mode,
  input  logic [CNT_W-1:0]  cur_addr,
  input  logic [PAGE_W-1:0] page,
  output logic [ADDR_W-1:0] addr
);
  always_comb begin
    if (word_mode) addr = {page[PAGE_W-1:1], cur_addr, 1'b0};
    else           addr = {page, cur_addr};
  end
endmodule

// File: rtl/dma_strobe_dec.sv
module dma_strobe_dec #(
  parameter int ADDR_W   = 24,
  parameter int EXT_W    = 3,
  parameter int LOW_BITS = 20
) (
  input  logic              dma_cyc,
  input  logic              mem_read,
  input  logic [EXT_W-1:0]  ext_hi,
  input  logic [ADDR_W-1:0] addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              low_rd,
  output logic              low_wr,
  output logic              aen,
  output logic              ale
);
  logic in_main, in_low;
  always_comb begin
    in_main = (ext_hi == '0);
    in_low  = in_main && (addr[ADDR_W-1:LOW_BITS] == '0);
    mem_rd  = dma_cyc && mem_read && in_main;
    mem_wr  = dma_cyc && !mem_read && in_main;
    low_rd  = dma_cyc && mem_read && in_low;
    low_wr  = dma_cyc && !mem_read && in_low;
    aen     = dma_cyc;
    ale     = dma_cyc;
  end
endmodule

// File: rtl/dma_addr_strobe_gen.sv
module dma_addr_strobe_gen #(
  parameter int NUM_CH        = 8,
  parameter int CNT_W         = 16,
  parameter int PAGE_W        = 8,
  parameter int EXT_W         = 3,
  parameter int WORD_CH_FIRST = 4,
  parameter int LOW_BITS      = 20,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int ADDR_W = CNT_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [1:0]        cfg_sel,
  input  logic [CNT_W-1:0]  cfg_data,
  input  logic              step,
  input  logic [CH_W-1:0]   act_ch,
  input  logic              mem_read,
  input  logic              dma_cyc,
  input  logic [EXT_W-1:0]  ext_hi,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              tc,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              low_rd_o,
  output logic              low_wr_o,
  output logic              aen_o,
  output logic              ale_o
);
  localparam logic [CH_W-1:0] WORD_FIRST_C = CH_W'(WORD_CH_FIRST);

  logic [CNT_W-1:0]  ch_cur  [NUM_CH];
  logic [PAGE_W-1:0] ch_page [NUM_CH];
  logic [NUM_CH-1:0] ch_tc;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dma_chan_regs #(.CNT_W(CNT_W), .PAGE_W(PAGE_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (cfg_we && (cfg_ch == CH_W'(g))),
      .wr_sel   (cfg_sel),
      .wr_data  (cfg_data),
      .step_hit (step && (act_ch == CH_W'(g))),
      .cur_addr (ch_cur[g]),
      .page     (ch_page[g]),
      .tc_now   (ch_tc[g])
    );
  end

  logic word_mode;
  assign word_mode = (act_ch >= WORD_FIRST_C);
  assign tc        = ch_tc[act_ch];

  dma_addr_form #(.CNT_W(CNT_W), .PAGE_W(PAGE_W)) u_form (
    .word_mode (word_mode),
    .cur_addr  (ch_cur[act_ch]),
    .page      (ch_page[act_ch]),
    .addr      (mem_addr)
  );

  dma_strobe_dec #(.ADDR_W(ADDR_W), .EXT_W(EXT_W), .LOW_BITS(LOW_BITS)) u_dec (
    .dma_cyc  (dma_cyc),
    .mem_read (mem_read),
    .ext_hi   (ext_hi),
    .addr     (mem_addr),
    .mem_rd   (mem_rd_o),
    .mem_wr   (mem_wr_o),
    .low_rd   (low_rd_o),
    .low_wr   (low_wr_o),
    .aen      (aen_o),
    .ale      (ale_o)
  );
endmodule

// File: rtl/dma_addr_strobe_chk.sv
module dma_addr_strobe_chk #(
  parameter int CH_W       = 3,
  parameter int ADDR_W     = 24,
  parameter int EXT_W      = 3,
  parameter int WORD_FIRST = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CH_W-1:0]   act_ch,
  input logic              dma_cyc,
  input logic [EXT_W-1:0]  ext_hi,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic              low_rd_o,
  input logic              low_wr_o,
  input logic              aen_o,
  input logic              ale_o
);
  localparam logic [CH_W-1:0] WF = CH_W'(WORD_FIRST);

  p_word_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_ch >= WF) |-> (mem_addr[0] == 1'b0));

  p_no_high_alias_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_hi != '0) |-> !(mem_rd_o || mem_wr_o || low_rd_o || low_wr_o));

  p_low_under_1m_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (low_rd_o || low_wr_o) |-> ((mem_rd_o || mem_wr_o) && (mem_addr[ADDR_W-1:20] == '0)));

  p_one_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o) && !(low_rd_o && low_wr_o) && !(mem_rd_o && low_wr_o));

  p_strobe_in_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o || mem_wr_o || low_rd_o || low_wr_o) |-> (aen_o && ale_o && dma_cyc));
endmodule

bind dma_addr_strobe_gen dma_addr_strobe_chk #(
  .CH_W(CH_W), .ADDR_W(ADDR_W), .EXT_W(EXT_W), .WORD_FIRST(WORD_CH_FIRST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .act_ch(act_ch), .dma_cyc(dma_cyc), .ext_hi(ext_hi),
  .mem_addr(mem_addr), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
  .low_rd_o(low_rd_o), .low_wr_o(low_wr_o), .aen_o(aen_o), .ale_o(ale_o)
);

// File: tb/test_dma_addr_strobe_gen.sv
module test_dma_addr_strobe_gen;
  logic        clk, rst_n, cfg_we, step, mem_read, dma_cyc;
  logic [2:0]  cfg_ch, act_ch, ext_hi;
  logic [1:0]  cfg_sel;
  logic [15:0] cfg_data;
  logic [23:0] mem_addr;
  logic        tc, mem_rd_o, mem_wr_o, low_rd_o, low_wr_o, aen_o, ale_o;

  dma_addr_strobe_gen i_dma_addr_strobe_gen (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    string       tag;
    logic [23:0] addr;
    logic [6:0]  flags;
  } item_t;

  item_t q[$];
  event  chk_ev;
  int    n_chk = 0, n_fail = 0;
  bit    done = 0;

  function automatic logic [6:0] model_flags(logic [23:0] a, logic t);
    logic in16, in1;
    in16 = (ext_hi == 3'd0);
    in1  = in16 && (a[23:20] == 4'd0);
    return {t, dma_cyc & mem_read & in16, dma_cyc & ~mem_read & in16,
            dma_cyc & mem_read & in1, dma_cyc & ~mem_read & in1, dma_cyc, dma_cyc};
  endfunction

  task automatic expect_out(string tag, logic [23:0] a, logic t);
    item_t it;
    it.tag = tag; it.addr = a; it.flags = model_flags(a, t);
    q.push_back(it);
    -> chk_ev;
  endtask

  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        item_t it;
        logic [6:0] act;
        it  = q.pop_front();
        act = {tc, mem_rd_o, mem_wr_o, low_rd_o, low_wr_o, aen_o, ale_o};
        n_chk++;
        if (mem_addr !== it.addr || act !== it.flags) begin
          n_fail++;
          $display("FAIL %s: addr %h flags %b, expected addr %h flags %b",
                   it.tag, mem_addr, act, it.addr, it.flags);
        end
      end
    end
  end

  task automatic wr(logic [2:0] ch, logic [1:0] sel, logic [15:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_ch = ch; cfg_sel = sel; cfg_data = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic settle_check(string tag, logic [23:0] a);
    @(negedge clk); #1;
    expect_out(tag, a, 1'b0);
  endtask

  task automatic do_step(string tag, logic exp_tc, logic [23:0] a_after);
    @(negedge clk);
    step = 1; #1;
    expect_out({tag, " tc"}, mem_addr_hold(), exp_tc);
    @(negedge clk);
    step = 0; #1;
    expect_out(tag, a_after, 1'b0);
  endtask

  logic [23:0] addr_now;
  function automatic logic [23:0] mem_addr_hold();
    return addr_now;
  endfunction

  initial begin
    rst_n = 0; cfg_we = 0; cfg_ch = 0; cfg_sel = 0; cfg_data = 0;
    step = 0; act_ch = 0; mem_read = 1; dma_cyc = 0; ext_hi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle_check("R12 reset state", 24'h000000);

    wr(3'd1, 2'd2, 16'h0012);
    wr(3'd1, 2'd0, 16'h3456);
    wr(3'd1, 2'd1, 16'h0002);
    wr(3'd1, 2'd3, 16'h0000);
    @(negedge clk); act_ch = 1; dma_cyc = 1; mem_read = 1;
    settle_check("R1 R7 R10 byte address", 24'h123456);
    addr_now = 24'h123456; do_step("R3 increment", 1'b0, 24'h123457);
    addr_now = 24'h123457; do_step("R4 count down", 1'b0, 24'h123458);
    addr_now = 24'h123458; do_step("R4 terminal count", 1'b1, 24'h123459);
    addr_now = 24'h123459; do_step("R6 wrap without reload", 1'b0, 24'h12345A);

    wr(3'd5, 2'd2, 16'h0034);
    wr(3'd5, 2'd0, 16'h8001);
    wr(3'd5, 2'd1, 16'h0001);
    wr(3'd5, 2'd3, 16'h0003);
    @(negedge clk); act_ch = 5;
    settle_check("R2 word address", 24'h350002);
    addr_now = 24'h350002; do_step("R3 decrement", 1'b0, 24'h350000);
    addr_now = 24'h350000; do_step("R5 auto reload", 1'b1, 24'h350002);
    addr_now = 24'h350002; do_step("R5 reloaded count", 1'b0, 24'h350000);

    wr(3'd2, 2'd2, 16'h000F);
    wr(3'd2, 2'd0, 16'hFFFF);
    @(negedge clk); act_ch = 2;
    settle_check("R8 below 1MB read", 24'h0FFFFF);
    @(negedge clk); mem_read = 0;
    settle_check("R9 write direction", 24'h0FFFFF);

    wr(3'd3, 2'd2, 16'h0010);
    wr(3'd3, 2'd0, 16'h0000);
    wr(3'd3, 2'd1, 16'h0005);
    @(negedge clk); act_ch = 3; mem_read = 1;
    settle_check("R8 at 1MB", 24'h100000);
    @(negedge clk); ext_hi = 3'd1;
    settle_check("R7 above 16MB", 24'h100000);
    @(negedge clk); ext_hi = 3'd0; dma_cyc = 0;
    settle_check("R10 idle", 24'h100000);

    @(negedge clk);
    step = 1; cfg_we = 1; cfg_ch = 3; cfg_sel = 2'd0; cfg_data = 16'h0042;
    @(negedge clk);
    step = 0; cfg_we = 0; #1;
    expect_out("R11 write over step", 24'h100042, 1'b0);

    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule